// File: doc/BRIEF.md
# Multi-cycle memory read sequencer

This block lets a processor core fetch one word from a slow memory that sits on a parallel address/data bus. The core raises a request with an address while the sequencer is idle. The sequencer then runs a fixed strobe protocol. It first drives the address for one cycle with the read strobe still high. It then pulls the active-low read strobe down and holds it there for a programmed number of wait cycles, so that the memory has time to answer.

On the clock edge that ends the low phase, the sequencer samples the data bus. In the same step the strobe returns high and a one-cycle ready pulse carries the captured word back to the core. While a transfer is under way, a busy flag tells the core that further requests will not be taken. The wait length is a parameter. With its default of one wait cycle, a read takes four cycles from the address cycle to the ready cycle.

Top module: `mrd_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `mem_rd_n` is 1, `mem_addr` is 0, `core_busy` is 0 and `core_rdy` is 0.
- R2: A request (`core_req` = 1) seen at a clock edge while idle is accepted. In the next cycle (the address cycle) `mem_addr` equals the requested address, `core_busy` is 1 and `mem_rd_n` is still 1.
- R3: `mem_rd_n` goes low in the cycle after the address cycle. It stays low for exactly WAIT_CYC+1 consecutive cycles, and it is never low while `core_busy` is 0.
- R4: `mem_rd_n` returns to 1 in the same cycle that `core_rdy` is 1. In that cycle `core_rdata` equals the value `mem_data` carried at the clock edge that ended the last low cycle.
- R5: A read spans WAIT_CYC+3 cycles, from the address cycle through the ready cycle. That is four cycles with the default WAIT_CYC of 1.
- R6: `core_rdy` is high for exactly one cycle per read, and `core_busy` is 0 in that cycle.
- R7: A request made while `core_busy` is 1 is ignored. `mem_addr` does not change, and no second transfer or extra ready pulse follows.
- R8: `mem_addr` is stable from the address cycle through the ready cycle.
- R9: A request presented during the ready cycle is accepted at the next edge, so reads can run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Core read request, sampled while idle |
| core_addr | input | AW | Address of the requested word |
| core_busy | output | 1 | A transfer is in progress; requests are ignored |
| core_rdy | output | 1 | One-cycle pulse: `core_rdata` holds the read word |
| core_rdata | output | DW | Captured read data |
| mem_addr | output | AW | Memory address bus |
| mem_rd_n | output | 1 | Active-low memory read strobe |
| mem_data | input | DW | Memory data bus |

## Verification
The assertions check the following on every cycle:
- the reset state;
- the address and strobe level in the cycle a transfer starts;
- that the strobe is low only while busy;
- the exact length of every low phase, measured by a counter;
- that the strobe's rising edge coincides with a single-cycle ready pulse;
- that the address is held steady while busy.

Some properties can only be shown by the bench's scenarios:
- the captured data matches what the memory model drove for that address;
- requests raised during a transfer leave no trace;
- a request placed in the ready cycle starts the next read without a gap.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_LOW   = 2'd2
  } mrd_state_e;
endpackage

// File: rtl/mrd_wait_ctr.sv
module mrd_wait_ctr #(
  parameter int WAIT_CYC = 1,
  parameter int CW       = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dec,
  output logic zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(WAIT_CYC);
    end else if (dec && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/mrd_ctrl.sv
module mrd_ctrl
  import mrd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic wait_zero,
  output logic accept,
  output logic load,
  output logic dec,
  output logic finish,
  output logic busy,
  output logic rd_n,
  output logic rdy
);
  mrd_state_e state, state_nx;

  always_comb begin
    accept   = (state == ST_IDLE) && req;
    load     = (state == ST_SETUP);
    dec      = (state == ST_LOW);
    finish   = (state == ST_LOW) && wait_zero;
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (req) state_nx = ST_SETUP;
      ST_SETUP: state_nx = ST_LOW;
      ST_LOW:   if (wait_zero) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      rd_n  <= 1'b1;
      rdy   <= 1'b0;
    end else begin
      state <= state_nx;
      rdy   <= finish;
      if (accept) busy <= 1'b1;
      else if (finish) busy <= 1'b0;
      if (load) rd_n <= 1'b0;
      else if (finish) rd_n <= 1'b1;
    end
  end
endmodule

// File: rtl/mrd_datapath.sv
module mrd_datapath #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] bus_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      rdata    <= '0;
    end else begin
      if (accept)  bus_addr <= req_addr;
      if (capture) rdata    <= bus_data;
    end
  end
endmodule

// File: rtl/mrd_seq.sv
module mrd_seq #(
  parameter int AW       = 20,
  parameter int DW       = 16,
  parameter int WAIT_CYC = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          core_req,
  input  logic [AW-1:0] core_addr,
  output logic          core_busy,
  output logic          core_rdy,
  output logic [DW-1:0] core_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_n,
  input  logic [DW-1:0] mem_data
);
  localparam int CW = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);

  logic accept, load, dec, finish, wait_zero;

  mrd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req(core_req), .wait_zero(wait_zero),
    .accept(accept), .load(load), .dec(dec), .finish(finish),
    .busy(core_busy), .rd_n(mem_rd_n), .rdy(core_rdy)
  );

  mrd_wait_ctr #(.WAIT_CYC(WAIT_CYC), .CW(CW)) u_wait (
    .clk(clk), .rst(rst), .load(load), .dec(dec), .zero(wait_zero)
  );

  mrd_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .capture(finish),
    .req_addr(core_addr), .bus_data(mem_data),
    .bus_addr(mem_addr), .rdata(core_rdata)
  );
endmodule

// File: rtl/mrd_seq_chk.sv
module mrd_seq_chk #(
  parameter int AW       = 20,
  parameter int WAIT_CYC = 1
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] core_addr,
  input logic          core_busy,
  input logic          core_rdy,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd_n
);
  localparam int LW = $clog2(WAIT_CYC + 3);
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) low_cnt <= '0;
    else if (!mem_rd_n) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (mem_rd_n && !core_busy && !core_rdy && mem_addr == '0)); // R1
  AST_START_STROBE_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(core_busy) |-> mem_rd_n); // R2
  AST_START_ADDR: assert property (@(posedge clk) disable iff (rst)
    $rose(core_busy) |-> (mem_addr == $past(core_addr))); // R2
  AST_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    !mem_rd_n |-> core_busy); // R3
  AST_LOW_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_n) |-> (low_cnt == LW'(WAIT_CYC + 1))); // R3
  AST_RISE_WITH_RDY: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_n) |-> (core_rdy && !core_busy)); // R4
  AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    core_rdy |=> !core_rdy); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    core_busy |=> $stable(mem_addr)); // R8
endmodule

bind mrd_seq mrd_seq_chk #(.AW(AW), .WAIT_CYC(WAIT_CYC)) u_chk (
  .clk(clk), .rst(rst), .core_addr(core_addr), .core_busy(core_busy),
  .core_rdy(core_rdy), .mem_addr(mem_addr), .mem_rd_n(mem_rd_n)
);

// File: tb/mrd_seq_test.sv
module mrd_seq_test;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int WAIT_CYC = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic core_req = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic core_busy, core_rdy, mem_rd_n;
  logic [DW-1:0] core_rdata, mem_data;
  logic [AW-1:0] mem_addr;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];
  logic prev_rdy = 1'b0;

  always #2.5 clk = ~clk;

  mrd_seq #(.AW(AW), .DW(DW), .WAIT_CYC(WAIT_CYC)) uut (.*);

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
    return (a[DW-1:0] ^ 16'hA5C3) + DW'(a[AW-1:DW]);
  endfunction

  // Memory model: valid word only while the strobe is low
  assign mem_data = mem_rd_n ? 16'hFFFF : mem_fn(mem_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard pop on each ready pulse (R4, R6)
  always @(negedge clk) begin
    if (!rst) begin
      if (core_rdy) begin
        if (exp_q.size() == 0) chk("R6 unexpected ready", 32'(core_rdy), 32'd0);
        else chk("R4 read data", 32'(core_rdata), 32'(exp_q.pop_front()));
        chk("R6 single pulse", 32'(prev_rdy), 32'd0);
      end
      prev_rdy <= core_rdy;
    end
  end

  // pre: request already driven in the previous ready cycle
  // spam: raise stray requests during the low phase (R7)
  // chain/nxt: present the next request in the ready cycle (R9)
  task automatic do_read(input logic [AW-1:0] a, input bit pre, input bit spam,
                         input bit chain, input logic [AW-1:0] nxt);
    exp_q.push_back(mem_fn(a));
    if (!pre) begin
      @(negedge clk);
      core_req = 1'b1;
      core_addr = a;
    end
    @(negedge clk);
    core_req = 1'b0;
    chk("R2 address cycle addr", 32'(mem_addr), 32'(a));
    chk("R2 address cycle busy", 32'(core_busy), 32'd1);
    chk("R2 address cycle strobe high", 32'(mem_rd_n), 32'd1);
    for (int i = 0; i <= WAIT_CYC; i++) begin
      if (spam) begin
        core_req = (i != WAIT_CYC);
        core_addr = a ^ 20'h0F0F0;
      end
      @(negedge clk);
      chk("R3 strobe low", 32'(mem_rd_n), 32'd0);
      chk("R8/R7 addr held", 32'(mem_addr), 32'(a));
    end
    core_req = 1'b0;
    @(negedge clk);
    chk("R5 ready at cycle WAIT_CYC+3", 32'(core_rdy), 32'd1);
    chk("R4 strobe back high", 32'(mem_rd_n), 32'd1);
    chk("R6 busy low in ready cycle", 32'(core_busy), 32'd0);
    chk("R8 addr held in ready cycle", 32'(mem_addr), 32'(a));
    if (chain) begin
      core_req = 1'b1;
      core_addr = nxt;
    end else begin
      @(negedge clk);
      chk("R7 no extra transfer", 32'(core_busy), 32'd0);
      chk("R7 no extra ready", 32'(core_rdy), 32'd0);
      chk("R7 addr untouched", 32'(mem_addr), 32'(a));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset strobe", 32'(mem_rd_n), 32'd1);
    chk("R1 reset addr", 32'(mem_addr), 32'd0);
    chk("R1 reset busy", 32'(core_busy), 32'd0);
    chk("R1 reset rdy", 32'(core_rdy), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", 32'(mem_rd_n), 32'd1);
    do_read(20'h08F10, 1'b0, 1'b0, 1'b0, '0);
    do_read(20'h90100, 1'b0, 1'b1, 1'b0, '0);
    do_read(20'hFFFFF, 1'b0, 1'b0, 1'b1, 20'h02920);
    do_read(20'h02920, 1'b1, 1'b0, 1'b1, 20'h00000);
    do_read(20'h00000, 1'b1, 1'b1, 1'b0, '0);
    repeat (3) @(negedge clk);
    chk("R6 all reads answered", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done || cycles > 20000) begin
      if (!done) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected done", cycles);
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule